// File: doc/BRIEF.md
# PLL Multiplier Control Register

This block is the digital control side of a frequency-multiplying PLL. Software programs it over a small register bus. The control word carries an enable, a 6-bit multiplier code and a 2-bit reference selector. The block checks each written value against the legal window and drops any field that falls outside it. It then reports three things to downstream clock logic: the effective multiplication ratio, the chosen reference index and a lock flag.

Each of up to four reference sources arrives as a one-cycle pulse on `refTick`, one pulse per edge of an external input. Before it reaches the loop, the block halves each source. While the PLL is enabled, a lock counter counts the halved edges of the selected source. The lock flag rises once that count reaches a programmable delay. When the PLL is disabled, the ratio reads 1, which means the halved reference passes through unchanged. Software enables the PLL and then polls the status bit until lock, giving up after a bounded number of reads.

Top module: `pll_mul_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the PLL disabled, with multiplier code 19, selector 0, lock delay `LOCK_RESET` (default 8), `ratio` = 1 and `locked` = 0.
- R2: While the enable is clear, `ratio` is 1, and writing a new multiplier code changes only the stored code, not `ratio`.
- R3: While enabled, `ratio` equals (code + 1) × 2, where the code is written in control word bits 29:24. The only legal values are 40 to 92 in steps of 2.
- R4: A control write whose code lies outside 19..45 keeps the previous code, while the enable and selector fields of that same write still take effect.
- R5: Selector bits 7:6 accept codes 0, 1 and 2, which appear on `refSel`. Code 3 is ignored and the previous selector is kept.
- R6: The lock counter advances once for every second pulse of the selected `refTick` bit, counting pulses since reset. Pulses on unselected bits do not advance it.
- R7: `locked` is high exactly when the PLL is enabled and the halved edges counted since the last (re)start reach the lock delay held at address 1 (bits 7:0). A delay of 0 gives lock on the clock after the enabling write.
- R8: While enabled, a control write that changes the stored code or selector clears `locked` and restarts the count. Rewriting unchanged values, or writing rejected values, leaves the lock untouched.
- R9: A control write with bit 31 clear drops `locked` and returns `ratio` to 1 on the next cycle.
- R10: The read map is as follows. Address 0 returns bit 31 = lock status, bit 30 = enable, bits 29:24 = code and bits 7:6 = selector, with all other bits 0. Address 1 returns the lock delay, and addresses 2 and 3 read 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (2) | Register address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| refTick | input | NUM_REF (3) | One pulse per edge of each external reference |
| ratio | output | 8 | Effective multiplication ratio (1 when disabled) |
| refSel | output | 2 | Selected reference index |
| locked | output | 1 | Lock status |

## Verification
The assertions assume that a pulse on `refTick` lasts exactly one clock and never coincides with a bus write. They also assume that `NUM_REF` is at most 4, so the 2-bit selector can hold every index. The bench sends each reference pulse in its own cycle and keeps every write in separate cycles. It raises the lock delay only while the PLL is disabled, because a saturating counter does not remember edges that arrived beyond the old delay. With those limits, the bench can predict lock from a plain count of halved edges per reference.

// File: rtl/pll_mul_pkg.sv
`timescale 1ns/1ps
package pll_mul_pkg;
  localparam int DATA_W    = 32;
  localparam int EN_BIT    = 31;  // write: enable request
  localparam int STAT_BIT  = 31;  // read: lock status
  localparam int EN_RD_BIT = 30;  // read: enable request
  localparam int MULT_LSB  = 24;
  localparam int MULT_W    = 6;
  localparam int SEL_LSB   = 6;
  localparam int SEL_W     = 2;
  localparam int RATIO_W   = MULT_W + 2;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DELAY = 1;

  typedef struct packed {
    logic loadEnable;
    logic enableVal;
    logic loadMult;
    logic loadSel;
    logic loadDelay;
    logic restart;
  } ctrlStrobes_t;
endpackage

// File: rtl/pll_ref_halver.sv
`timescale 1ns/1ps
module pll_ref_halver (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic halfEdge
);
  logic phaseQ;

  always_ff @(posedge clk) begin
    if (rst)       phaseQ <= 1'b0;
    else if (tick) phaseQ <= ~phaseQ;
  end

  // every second input pulse is one edge of the halved reference
  assign halfEdge = tick & phaseQ;
endmodule

// File: rtl/pll_mul_ctrl_logic.sv
`timescale 1ns/1ps
module pll_mul_ctrl_logic
  import pll_mul_pkg::*;
#(
  parameter int NUM_REF  = 3,
  parameter int MULT_MIN = 19,
  parameter int MULT_MAX = 45,
  parameter int ADDR_W   = 2
) (
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                curEnable,
  input  logic [MULT_W-1:0]   curMult,
  input  logic [SEL_W-1:0]    curSel,
  output ctrlStrobes_t        strobes
);
  logic              hitCtrl;
  logic              hitDelay;
  logic [MULT_W-1:0] newMult;
  logic [SEL_W-1:0]  newSel;
  logic              newEnable;
  logic              multOk;
  logic              selOk;
  logic              multChanged;
  logic              selChanged;

  always_comb begin
    hitCtrl   = wrEn && (addr == ADDR_W'(ADDR_CTRL));
    hitDelay  = wrEn && (addr == ADDR_W'(ADDR_DELAY));
    newMult   = wrData[MULT_LSB +: MULT_W];
    newSel    = wrData[SEL_LSB +: SEL_W];
    newEnable = wrData[EN_BIT];
    multOk    = (int'(newMult) >= MULT_MIN) && (int'(newMult) <= MULT_MAX);
    selOk     = int'(newSel) < NUM_REF;
    multChanged = multOk && (newMult != curMult);
    selChanged  = selOk && (newSel != curSel);

    strobes.loadEnable = hitCtrl;
    strobes.enableVal  = newEnable;
    strobes.loadMult   = hitCtrl && multOk;
    strobes.loadSel    = hitCtrl && selOk;
    strobes.loadDelay  = hitDelay;
    strobes.restart    = hitCtrl && newEnable &&
                         (!curEnable || multChanged || selChanged);
  end
endmodule

// File: rtl/pll_mul_datapath.sv
`timescale 1ns/1ps
module pll_mul_datapath
  import pll_mul_pkg::*;
#(
  parameter int NUM_REF    = 3,
  parameter int LOCK_W     = 8,
  parameter int LOCK_RESET = 8,
  parameter int MULT_RESET = 19,
  parameter int ADDR_W     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_REF-1:0]  refTick,
  output logic                enableQ,
  output logic [MULT_W-1:0]   multQ,
  output logic [SEL_W-1:0]    selQ,
  output logic [LOCK_W-1:0]   delayQ,
  output logic                locked,
  output logic [RATIO_W-1:0]  ratio,
  output logic [DATA_W-1:0]   rdData
);
  logic [NUM_REF-1:0] halfEdge;
  logic               selEdge;
  logic               enableNext;
  logic [LOCK_W-1:0]  lockCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= 1'b0;
      multQ   <= MULT_W'(MULT_RESET);
      selQ    <= '0;
      delayQ  <= LOCK_W'(LOCK_RESET);
    end else begin
      if (strobes.loadEnable) enableQ <= strobes.enableVal;
      if (strobes.loadMult)   multQ   <= wrData[MULT_LSB +: MULT_W];
      if (strobes.loadSel)    selQ    <= wrData[SEL_LSB +: SEL_W];
      if (strobes.loadDelay)  delayQ  <= wrData[LOCK_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : gHalve
    pll_ref_halver u_halver (
      .clk      (clk),
      .rst      (rst),
      .tick     (refTick[g]),
      .halfEdge (halfEdge[g])
    );
  end

  always_comb begin
    selEdge = 1'b0;
    for (int i = 0; i < NUM_REF; i++)
      if (selQ == SEL_W'(i)) selEdge = halfEdge[i];
  end

  assign enableNext = strobes.loadEnable ? strobes.enableVal : enableQ;

  always_ff @(posedge clk) begin
    if (rst)
      lockCnt <= '0;
    else if (strobes.restart || !enableNext)
      lockCnt <= '0;
    else if (selEdge && (lockCnt < delayQ))
      lockCnt <= lockCnt + LOCK_W'(1);
  end

  assign locked = enableQ && (lockCnt >= delayQ);

  always_comb begin
    if (enableQ) ratio = RATIO_W'((RATIO_W'(multQ) + RATIO_W'(1)) << 1);
    else         ratio = RATIO_W'(1);
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rdData[STAT_BIT]             = locked;
      rdData[EN_RD_BIT]            = enableQ;
      rdData[MULT_LSB +: MULT_W]   = multQ;
      rdData[SEL_LSB +: SEL_W]     = selQ;
    end else if (addr == ADDR_W'(ADDR_DELAY)) begin
      rdData[LOCK_W-1:0] = delayQ;
    end
  end
endmodule

// File: rtl/pll_mul_ctrl.sv
`timescale 1ns/1ps
module pll_mul_ctrl
  import pll_mul_pkg::*;
#(
  parameter int NUM_REF    = 3,
  parameter int MULT_MIN   = 19,
  parameter int MULT_MAX   = 45,
  parameter int MULT_RESET = 19,
  parameter int LOCK_W     = 8,
  parameter int LOCK_RESET = 8,
  parameter int ADDR_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  logic [NUM_REF-1:0]     refTick,
  output logic [RATIO_W-1:0]     ratio,
  output logic [SEL_W-1:0]       refSel,
  output logic                   locked
);
  ctrlStrobes_t      strobes;
  logic              enableQ;
  logic [MULT_W-1:0] multField;
  logic [LOCK_W-1:0] lockDelay;

  pll_mul_ctrl_logic #(
    .NUM_REF (NUM_REF), .MULT_MIN (MULT_MIN), .MULT_MAX (MULT_MAX), .ADDR_W (ADDR_W)
  ) u_ctrl (
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .curEnable (enableQ),
    .curMult   (multField),
    .curSel    (refSel),
    .strobes   (strobes)
  );

  pll_mul_datapath #(
    .NUM_REF (NUM_REF), .LOCK_W (LOCK_W), .LOCK_RESET (LOCK_RESET),
    .MULT_RESET (MULT_RESET), .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (wrData),
    .addr    (addr),
    .refTick (refTick),
    .enableQ (enableQ),
    .multQ   (multField),
    .selQ    (refSel),
    .delayQ  (lockDelay),
    .locked  (locked),
    .ratio   (ratio),
    .rdData  (rdData)
  );
endmodule

// File: rtl/pll_mul_ctrl_chk.sv
`timescale 1ns/1ps
module pll_mul_ctrl_chk #(
  parameter int NUM_REF  = 3,
  parameter int MULT_MIN = 19,
  parameter int MULT_MAX = 45,
  parameter int LOCK_W   = 8,
  parameter int ADDR_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [7:0]        ratio,
  input logic [1:0]        refSel,
  input logic              locked,
  input logic [5:0]        multField,
  input logic [LOCK_W-1:0] lockDelay
);
  logic ctrlWr;
  logic newMultOk;
  assign ctrlWr    = wrEn && (addr == '0);
  assign newMultOk = (int'(wrData[29:24]) >= MULT_MIN) && (int'(wrData[29:24]) <= MULT_MAX);

  assert_ratio_window_R3: assert property (@(posedge clk) disable iff (rst)
    (ratio == 8'd1) || ((int'(ratio) >= 2*(MULT_MIN+1)) && (int'(ratio) <= 2*(MULT_MAX+1)) && !ratio[0]));

  assert_sel_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(refSel) < NUM_REF);

  assert_sel_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && int'(wrData[7:6]) >= NUM_REF) |=> $stable(refSel));

  assert_mult_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && wrData[31] && ratio != 8'd1 && !newMultOk) |=> $stable(ratio));

  assert_disable_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && !wrData[31]) |=> (ratio == 8'd1 && !locked));

  assert_lock_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> ratio != 8'd1);

  assert_restart_on_change_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && wrData[31] && locked && lockDelay != '0 && newMultOk &&
     wrData[29:24] != multField) |=> !locked);
endmodule

bind pll_mul_ctrl pll_mul_ctrl_chk #(
  .NUM_REF (NUM_REF), .MULT_MIN (MULT_MIN), .MULT_MAX (MULT_MAX),
  .LOCK_W (LOCK_W), .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .ratio     (ratio),
  .refSel    (refSel),
  .locked    (locked),
  .multField (multField),
  .lockDelay (lockDelay)
);

// File: tb/test_pll_mul_ctrl.sv
`timescale 1ns/1ps
module test_pll_mul_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  refTick = '0;
  logic [7:0]  ratio;
  logic [1:0]  refSel;
  logic        locked;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  bit       expEn = 0;
  int       expMult = 19;
  int       expSel = 0;
  int       expDelay = 8;
  bit       phase [3] = '{0, 0, 0};
  int       edges = 0;

  always #2 clk = ~clk;

  pll_mul_ctrl i_pll_mul_ctrl (
    .clk (clk), .rst (rst), .wrEn (wrEn), .addr (addr), .wrData (wrData),
    .rdData (rdData), .refTick (refTick), .ratio (ratio), .refSel (refSel),
    .locked (locked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int expRatio();
    return expEn ? (expMult + 1) * 2 : 1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bit nEn; int m; int s; bit mOk; bit sOk; bit rs;
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) begin
      nEn = d[31]; m = int'(d[29:24]); s = int'(d[7:6]);
      mOk = (m >= 19) && (m <= 45);
      sOk = s < 3;
      rs = nEn && (!expEn || (mOk && m != expMult) || (sOk && s != expSel));
      expEn = nEn;
      if (mOk) expMult = m;
      if (sOk) expSel = s;
      if (rs || !nEn) edges = 0;
    end else if (a == 2'd1) begin
      expDelay = int'(d[7:0]);
    end
  endtask

  task automatic tick(input int r);
    @(negedge clk);
    refTick = 3'(1 << r);
    @(negedge clk);
    refTick = '0;
    if (phase[r] && expEn && r == expSel) edges++;
    phase[r] = !phase[r];
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input int m, input int s);
    return {en, 1'b0, 6'(m), 16'd0, 2'(s), 6'd0};
  endfunction

  function automatic logic [31:0] expCtrlRead();
    return {(expEn && edges >= expDelay), expEn, 6'(expMult), 16'd0, 2'(expSel), 6'd0};
  endfunction

  task automatic checkLock(input string req);
    check(req, 32'(locked), 32'(expEn && edges >= expDelay));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R10 read map after reset
    check("R1 ratio", 32'(ratio), 32'd1);
    check("R1 refSel", 32'(refSel), 32'd0);
    check("R1 locked", 32'(locked), 32'd0);
    rd(2'd0, v); check("R1 R10 ctrl read", v, 32'h1300_0000);
    rd(2'd1, v); check("R1 R10 delay read", v, 32'd8);

    // R3/R4 sweep every code with enable set
    for (int m = 0; m < 64; m++) begin
      wr(2'd0, ctrlWord(1'b1, m, 0));
      check((m >= 19 && m <= 45) ? "R3 ratio" : "R4 reject ratio", 32'(ratio), 32'(expRatio()));
      rd(2'd0, v); check("R4 R10 code read", {2'b0, v[29:0]}, {2'b0, expCtrlRead() & 32'h3FFF_FFFF});
    end

    // R9 disable then R2 passthrough with code changes
    wr(2'd0, ctrlWord(1'b0, 40, 0));
    check("R9 ratio after disable", 32'(ratio), 32'd1);
    for (int m = 17; m < 48; m += 3) begin
      wr(2'd0, ctrlWord(1'b0, m, 0));
      check("R2 ratio while disabled", 32'(ratio), 32'd1);
      rd(2'd0, v); check("R2 R4 stored code", 32'(v[29:24]), 32'(expMult));
    end

    // R5 selector sweep, disabled, plus illegal code mixed with legal enable
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, ctrlWord(1'b0, 30, s));
      check(s < 3 ? "R5 refSel" : "R5 reject sel3", 32'(refSel), 32'(expSel));
    end
    wr(2'd0, ctrlWord(1'b1, 50, 3));
    check("R4 enable applied with bad code", 32'(ratio), 32'(expRatio()));
    check("R5 sel3 kept old", 32'(refSel), 32'(expSel));
    wr(2'd0, ctrlWord(1'b0, 30, 0));

    // R6/R7 lock timing per reference and delay
    for (int di = 0; di < 4; di++) begin
      for (int s = 0; s < 3; s++) begin
        int d;
        d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 5;
        wr(2'd0, ctrlWord(1'b0, 25, s));
        wr(2'd1, 32'(d));
        wr(2'd0, ctrlWord(1'b1, 25, s));
        checkLock("R7 lock after enable");
        for (int it = 0; it < 2 * d + 4; it++) begin
          tick((s + 1) % 3);
          checkLock("R6 unselected pulse");
          tick(s);
          checkLock("R6 R7 selected pulse");
        end
        rd(2'd0, v); check("R10 status bit", v, expCtrlRead());
      end
    end

    // R8 restart behaviour
    wr(2'd0, ctrlWord(1'b0, 25, 0));
    wr(2'd1, 32'd2);
    wr(2'd0, ctrlWord(1'b1, 25, 0));
    for (int it = 0; it < 6; it++) tick(0);
    checkLock("R8 initial lock");
    check("R8 locked set", 32'(locked), 32'd1);
    wr(2'd0, ctrlWord(1'b1, 25, 0));
    check("R8 same values keep lock", 32'(locked), 32'd1);
    wr(2'd0, ctrlWord(1'b1, 60, 3));
    check("R8 rejected values keep lock", 32'(locked), 32'd1);
    wr(2'd0, ctrlWord(1'b1, 33, 0));
    check("R8 new code drops lock", 32'(locked), 32'd0);
    checkLock("R8 model agrees");
    for (int it = 0; it < 6; it++) begin tick(0); checkLock("R8 relock"); end
    wr(2'd0, ctrlWord(1'b1, 33, 2));
    check("R8 new sel drops lock", 32'(locked), 32'd0);
    for (int it = 0; it < 6; it++) begin tick(2); checkLock("R8 relock sel2"); end
    check("R3 ratio 33", 32'(ratio), 32'd68);

    // R9 disable while locked
    wr(2'd0, ctrlWord(1'b0, 33, 2));
    check("R9 lock dropped", 32'(locked), 32'd0);
    check("R9 ratio one", 32'(ratio), 32'd1);

    // R10 unused addresses
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10 addr2 reads 0", v, 32'd0);
    rd(2'd3, v); check("R10 addr3 reads 0", v, 32'd0);
    rd(2'd0, v); check("R10 ctrl untouched", v, expCtrlRead());
    rd(2'd1, v); check("R10 delay untouched", v, 32'(expDelay));

    // R1 reset again from a busy state
    wr(2'd0, ctrlWord(1'b1, 40, 1));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 ratio after reset", 32'(ratio), 32'd1);
    check("R1 sel after reset", 32'(refSel), 32'd0);
    rd(2'd0, v); check("R1 ctrl after reset", v, 32'h1300_0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule